// File: doc/BRIEF.md
# Control-Transfer Target Alignment Checker

This block sits in the execute/redirect stage of a small 32-bit core. For each resolved instruction it decides one of two outcomes. The first is to steer fetch to a new address and let a jump write its link register. The second is to refuse the transfer and request an instruction-address-misaligned trap. Targets that are only 2-byte aligned are legal while the compressed-instruction extension is enabled. They become faults once software turns that extension off. The check also covers the plain sequential successor and the return address of a machine-mode exception return, not only jumps.

One request is presented per cycle with `in_valid`. The block captures it in a single register stage. All outputs are then resolved combinationally from that registered request, so they appear in the cycle after the request. A trap wins over the redirect it would otherwise have caused.

Top module: `cta_align_checker`

## Requirements
- R1: While reset is held and in the first cycle after it, `redirect_valid`, `trap_req` and `link_we` are low.
- R2: Outputs describe the request presented in the previous cycle. A cycle after one with `in_valid` low shows no redirect, no trap and no link write. `in_kind` codes: 0 sequential, 1 JAL, 2 JALR, 3 conditional branch, 4 exception return.
- R3: For JALR the effective target is `in_jalr_sum` with bit 0 forced to zero, so an odd sum alone never traps.
- R4: With `in_c_enable` low, a JAL, a JALR or a taken branch whose effective target has bit 1 set raises `trap_req` with `trap_cause` 0 and leaves `redirect_valid` low. Otherwise it redirects to the effective target. JAL and branch use `in_target`.
- R5: With `in_c_enable` high, no request ever raises `trap_req`, and 2-byte-aligned targets redirect normally.
- R6: A branch with `in_taken` low neither traps nor redirects, whatever its target.
- R7: A JAL or JALR that does not trap asserts `link_we`. One that traps keeps `link_we` low. No other kind asserts it.
- R8: On a jump or branch trap, `trap_epc` is `in_pc` of that instruction and `trap_tval` is its effective target.
- R9: A sequential request with `in_c_enable` low traps when `in_pc`+4 has bit 1 set. Both `trap_epc` and `trap_tval` are then `in_pc`+4. It never redirects.
- R10: An exception return redirects to `in_saved_epc` with bit 0 cleared. With `in_c_enable` low and bit 1 of that address set, it traps instead, with `trap_epc` and `trap_tval` both equal to that address.
- R11: `trap_req` and `redirect_valid` are never high together. Each lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_kind | input | 3 | Transfer class (0 seq, 1 JAL, 2 JALR, 3 branch, 4 return) |
| in_taken | input | 1 | Branch resolved taken |
| in_c_enable | input | 1 | Compressed extension enabled |
| in_pc | input | 32 | Address of the instruction |
| in_target | input | 32 | Computed JAL/branch target |
| in_jalr_sum | input | 32 | rs1 + immediate for JALR |
| in_saved_epc | input | 32 | Saved exception PC used by the return |
| redirect_valid | output | 1 | Fetch must go to `redirect_pc` |
| redirect_pc | output | 32 | New fetch address |
| trap_req | output | 1 | Misaligned-fetch trap request |
| trap_cause | output | 4 | Trap cause code (0) |
| trap_tval | output | 32 | Faulting target address |
| trap_epc | output | 32 | Exception PC to record |
| link_we | output | 1 | Link register write enable |

## Verification
The reference model is tried with directed pairs that differ only in the extension bit. These pairs separate a bit-1 target that traps from the same target redirecting legally. Odd JALR sums with bit 1 clear or set tell the bit-0 clearing apart from a real bit-1 fault. Taken and not-taken branches with the same misaligned target show the not-taken exemption. Sequential and return requests check that the recorded exception PC is the faulting fetch address rather than the instruction address. A long pseudo-random stream mixes all kinds, bubbles and extension toggles so that back-to-back requests expose any state leaking between cycles.

// File: rtl/cta_pkg.sv
package cta_pkg;

    parameter int XLEN = 32;
    localparam int CAUSE_W = 4;
    localparam int KIND_W = 3;
    localparam int INSN_BYTES = 4;
    localparam int HALF_BIT = 1;

    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_MISALIGN = '0;

    typedef enum logic [KIND_W-1:0] {
        XFER_SEQ  = 3'd0,
        XFER_JAL  = 3'd1,
        XFER_JALR = 3'd2,
        XFER_BR   = 3'd3,
        XFER_MRET = 3'd4
    } xfer_kind_e;

    typedef struct packed {
        logic            valid;
        xfer_kind_e      kind;
        logic            taken;
        logic            c_en;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] jalr_sum;
        logic [XLEN-1:0] saved_epc;
    } xfer_req_t;

    typedef struct packed {
        logic            check;
        logic            redirect;
        logic            link;
        logic            epc_is_target;
        logic [XLEN-1:0] target;
    } xfer_plan_t;

    typedef struct packed {
        logic               redirect_valid;
        logic [XLEN-1:0]    redirect_pc;
        logic               trap_req;
        logic [CAUSE_W-1:0] cause;
        logic [XLEN-1:0]    tval;
        logic [XLEN-1:0]    epc;
        logic               link_we;
    } xfer_result_t;

    function automatic logic [XLEN-1:0] clear_lsb(input logic [XLEN-1:0] a);
        return {a[XLEN-1:1], 1'b0};
    endfunction

    function automatic logic half_misaligned(input logic [XLEN-1:0] a, input logic c_en);
        return !c_en && a[HALF_BIT];
    endfunction

endpackage

// File: rtl/cta_target_sel.sv
module cta_target_sel
    import cta_pkg::*;
(
    input  xfer_req_t  req,
    output xfer_plan_t plan
);
    localparam logic [XLEN-1:0] SEQ_STEP = XLEN'(INSN_BYTES);

    always_comb begin
        plan = '0;
        unique case (req.kind)
            XFER_SEQ: begin
                plan.check         = 1'b1;
                plan.epc_is_target = 1'b1;
                plan.target        = req.pc + SEQ_STEP;
            end
            XFER_JAL: begin
                plan.check    = 1'b1;
                plan.redirect = 1'b1;
                plan.link     = 1'b1;
                plan.target   = req.target;
            end
            XFER_JALR: begin
                plan.check    = 1'b1;
                plan.redirect = 1'b1;
                plan.link     = 1'b1;
                plan.target   = clear_lsb(req.jalr_sum);
            end
            XFER_BR: begin
                plan.check    = req.taken;
                plan.redirect = req.taken;
                plan.target   = req.target;
            end
            XFER_MRET: begin
                plan.check         = 1'b1;
                plan.redirect      = 1'b1;
                plan.epc_is_target = 1'b1;
                plan.target        = clear_lsb(req.saved_epc);
            end
            default: plan = '0;
        endcase
    end
endmodule

// File: rtl/cta_align_judge.sv
module cta_align_judge
    import cta_pkg::*;
(
    input  logic            valid,
    input  logic            c_en,
    input  logic [XLEN-1:0] pc,
    input  xfer_plan_t      plan,
    output xfer_result_t    res
);
    logic fault;

    always_comb begin
        fault = valid && plan.check && half_misaligned(plan.target, c_en);
        res                = '0;
        res.trap_req       = fault;
        res.cause          = CAUSE_FETCH_MISALIGN;
        res.redirect_valid = valid && plan.redirect && !fault;
        res.link_we        = valid && plan.link && !fault;
        if (fault) begin
            res.tval = plan.target;
            res.epc  = plan.epc_is_target ? plan.target : pc;
        end
        if (res.redirect_valid) begin
            res.redirect_pc = plan.target;
        end
    end
endmodule

// File: rtl/cta_align_checker.sv
module cta_align_checker
    import cta_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [KIND_W-1:0]  in_kind,
    input  logic               in_taken,
    input  logic               in_c_enable,
    input  logic [XLEN-1:0]    in_pc,
    input  logic [XLEN-1:0]    in_target,
    input  logic [XLEN-1:0]    in_jalr_sum,
    input  logic [XLEN-1:0]    in_saved_epc,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic               trap_req,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [XLEN-1:0]    trap_tval,
    output logic [XLEN-1:0]    trap_epc,
    output logic               link_we
);
    xfer_req_t    req_q;
    xfer_req_t    req_d;
    xfer_plan_t   plan;
    xfer_result_t res;

    always_comb begin
        req_d.valid     = in_valid;
        req_d.kind      = xfer_kind_e'(in_kind);
        req_d.taken     = in_taken;
        req_d.c_en      = in_c_enable;
        req_d.pc        = in_pc;
        req_d.target    = in_target;
        req_d.jalr_sum  = in_jalr_sum;
        req_d.saved_epc = in_saved_epc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    cta_target_sel u_sel (
        .req  (req_q),
        .plan (plan)
    );

    cta_align_judge u_judge (
        .valid (req_q.valid),
        .c_en  (req_q.c_en),
        .pc    (req_q.pc),
        .plan  (plan),
        .res   (res)
    );

    assign redirect_valid = res.redirect_valid;
    assign redirect_pc    = res.redirect_pc;
    assign trap_req       = res.trap_req;
    assign trap_cause     = res.cause;
    assign trap_tval      = res.tval;
    assign trap_epc       = res.epc;
    assign link_we        = res.link_we;
endmodule

// File: rtl/cta_align_chk.sv
module cta_align_chk
    import cta_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [KIND_W-1:0]  in_kind,
    input logic               in_taken,
    input logic               in_c_enable,
    input logic [XLEN-1:0]    in_jalr_sum,
    input logic               redirect_valid,
    input logic [XLEN-1:0]    redirect_pc,
    input logic               trap_req,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic               link_we
);
    logic seen_clk;
    always_ff @(posedge clk) begin
        if (rst) seen_clk <= 1'b0;
        else     seen_clk <= 1'b1;
    end

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(trap_req && redirect_valid));

    assert_cause_zero_R4: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> trap_cause == CAUSE_FETCH_MISALIGN);

    assert_no_link_on_trap_R7: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> !link_we);

    assert_idle_after_bubble_R2: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && !$past(in_valid)) |-> !(trap_req || redirect_valid || link_we));

    assert_c_on_no_trap_R5: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && $past(in_valid && in_c_enable)) |-> !trap_req);

    assert_not_taken_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && $past(in_valid && in_kind == 3'd3 && !in_taken)) |-> !(trap_req || redirect_valid));

    assert_jalr_even_R3: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && $past(in_valid && in_kind == 3'd2 && !in_jalr_sum[1])) |->
            (redirect_valid && !redirect_pc[0]));
endmodule

bind cta_align_checker cta_align_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_kind        (in_kind),
    .in_taken       (in_taken),
    .in_c_enable    (in_c_enable),
    .in_jalr_sum    (in_jalr_sum),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .trap_req       (trap_req),
    .trap_cause     (trap_cause),
    .link_we        (link_we)
);

// File: tb/tb_cta_align_checker.sv
`timescale 1ns/1ps
module tb_cta_align_checker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_kind = 3'd0;
    logic        in_taken = 1'b0;
    logic        in_c_enable = 1'b0;
    logic [31:0] in_pc = '0, in_target = '0, in_jalr_sum = '0, in_saved_epc = '0;
    logic        redirect_valid, trap_req, link_we;
    logic [31:0] redirect_pc, trap_tval, trap_epc;
    logic [3:0]  trap_cause;

    always #4 clk = ~clk;

    cta_align_checker dut (.*);

    int checks = 0, errors = 0, cycles = 0;
    logic done = 1'b0;

    // previous request, as the model remembers it
    logic        p_valid = 1'b0, p_taken = 1'b0, p_c = 1'b0;
    int          p_kind = 0;
    logic [31:0] p_pc = '0, p_tgt = '0, p_sum = '0, p_epc = '0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model evaluated at each negedge on the request held from last cycle
    task automatic compare_model();
        logic e_rv = 0, e_tr = 0, e_lw = 0;
        logic [31:0] e_rpc = 0, e_tv = 0, e_ep = 0, dest = 0;
        string tag = "R2";
        bit bad;
        if (p_valid) begin
            case (p_kind)
                0: begin
                    tag = "R9"; dest = p_pc + 32'd4;
                    if (!p_c && dest[1]) begin e_tr = 1; e_tv = dest; e_ep = dest; end
                end
                1, 2: begin
                    tag = (p_kind == 2) ? "R3" : "R7";
                    dest = (p_kind == 2) ? (p_sum & ~32'd1) : p_tgt;
                    if (!p_c && dest[1]) begin e_tr = 1; e_tv = dest; e_ep = p_pc; tag = "R8"; end
                    else begin e_rv = 1; e_rpc = dest; e_lw = 1; end
                end
                3: begin
                    tag = p_taken ? "R4" : "R6";
                    if (p_taken) begin
                        if (!p_c && p_tgt[1]) begin e_tr = 1; e_tv = p_tgt; e_ep = p_pc; tag = "R8"; end
                        else begin e_rv = 1; e_rpc = p_tgt; end
                    end
                end
                4: begin
                    tag = "R10"; dest = p_epc & ~32'd1;
                    if (!p_c && dest[1]) begin e_tr = 1; e_tv = dest; e_ep = dest; end
                    else begin e_rv = 1; e_rpc = dest; end
                end
                default: ;
            endcase
            if (p_c && tag != "R6" && tag != "R9") tag = "R5";
        end
        check(tag, 32'(redirect_valid), 32'(e_rv), "redirect_valid");
        check(tag, 32'(trap_req), 32'(e_tr), "trap_req");
        check("R7", 32'(link_we), 32'(e_lw), "link_we");
        if (e_rv) check(tag, redirect_pc, e_rpc, "redirect_pc");
        if (e_tr) begin
            check("R4", 32'(trap_cause), 32'd0, "trap_cause");
            check("R8", trap_tval, e_tv, "trap_tval");
            check(tag, trap_epc, e_ep, "trap_epc");
        end
        bad = trap_req && redirect_valid;
        check("R11", 32'(bad), 32'd0, "trap_and_redirect");
    endtask

    task automatic drive(logic v, int k, logic tk, logic c, logic [31:0] pc,
                         logic [31:0] tgt, logic [31:0] sum, logic [31:0] epc);
        @(negedge clk);
        compare_model();
        in_valid = v; in_kind = 3'(k); in_taken = tk; in_c_enable = c;
        in_pc = pc; in_target = tgt; in_jalr_sum = sum; in_saved_epc = epc;
        p_valid = v; p_kind = k; p_taken = tk; p_c = c;
        p_pc = pc; p_tgt = tgt; p_sum = sum; p_epc = epc;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R1: outputs low under reset
        check("R1", {29'd0, redirect_valid, trap_req, link_we}, 32'd0, "outputs_in_reset");
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1", {29'd0, redirect_valid, trap_req, link_we}, 32'd0, "outputs_after_reset");

        // R4/R5: JAL to a 2-byte-aligned target, extension off then on
        drive(1, 1, 0, 0, 32'h100, 32'h202, 0, 0);
        drive(1, 1, 0, 1, 32'h100, 32'h202, 0, 0);
        drive(1, 1, 0, 0, 32'h100, 32'h204, 0, 0);
        // R3: odd JALR sums
        drive(1, 2, 0, 0, 32'h140, 0, 32'h301, 0);
        drive(1, 2, 0, 0, 32'h140, 0, 32'h303, 0);
        drive(1, 2, 0, 1, 32'h140, 0, 32'h303, 0);
        // R6: not-taken branch with bad target, then taken
        drive(1, 3, 0, 0, 32'h180, 32'h40a, 0, 0);
        drive(1, 3, 1, 0, 32'h180, 32'h40a, 0, 0);
        drive(1, 3, 1, 1, 32'h180, 32'h40a, 0, 0);
        // R9: sequential after disabling the extension at a half-aligned pc
        drive(1, 0, 0, 0, 32'h1fe, 0, 0, 0);
        drive(1, 0, 0, 1, 32'h1fe, 0, 0, 0);
        drive(1, 0, 0, 0, 32'h200, 0, 0, 0);
        // R10: exception return
        drive(1, 4, 0, 0, 32'h500, 0, 0, 32'h602);
        drive(1, 4, 0, 0, 32'h500, 0, 0, 32'h603);
        drive(1, 4, 0, 1, 32'h500, 0, 0, 32'h602);
        drive(1, 4, 0, 0, 32'h500, 0, 0, 32'h605);
        // R2: bubble with fields that would trap
        drive(0, 1, 1, 0, 32'h100, 32'h202, 32'h202, 32'h202);
        drive(0, 0, 0, 0, 0, 0, 0, 0);

        for (int i = 0; i < 600; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            drive(lf[7:0] != 8'd0, int'(lf[10:8]) % 5, lf[11], lf[12],
                  {lf[31:4], lf[15:14], 2'b00} ^ {lf[3:0], 28'd0},
                  {lf[27:2], lf[13], 5'd0} | {30'd0, lf[16], 1'b0},
                  lf ^ 32'h5a5a_0000, {lf[15:0], lf[31:16]});
        end
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule